// File: doc/BRIEF.md
# SPI FIFO and Transfer Control Block

This block sits between a register bus and the shift engine of an SPI controller. It holds a small transmit queue that software fills word by word and the engine drains, and a small receive queue that the engine fills and software drains. A status word reports how full each queue is, whether a block is running, whether the last block has finished, and two sticky error flags. A control word holds a block length, two completion-interrupt enables, two request-level selects and a start bit.

Software writes the control word with the start bit set. The block then pulses a start strobe to the engine and presents the programmed length. It counts the words the engine reports as shifted and, after the last one, drops busy, raises ready and clears the start bit. The interrupt output follows ready, gated by the enables, until software clears ready by writing a one to it. The queue-level request outputs let a transfer agent move data in single words or in bursts of four.

Register map on the 2-bit word address: 0 is status, 1 is control, 2 is the transmit data port (write), and 3 is the receive data port (read).

Top module: `spi_buf_ctrl`

## Requirements
- R1: After reset the status word (address 0) reads 0x0280_0000: receive empty (bit 25) and transmit empty (bit 23) are set, and busy (31), ready (30), the error flags and the full flags are clear. `irq` is low.
- R2: The transmit queue holds 4 words of 32 bits. Words written to address 2 appear on `eng_tx_data` in write order, one per `eng_tx_pop`. After four writes, status bit 22 (transmit full) is set and bit 23 is clear.
- R3: A write to address 2 while the transmit queue is full is dropped and sets the sticky overflow flag, status bit 26. Writing a 1 to status bit 26 clears that flag.
- R4: A read of address 3 while the receive queue is empty returns 0 and sets the sticky underflow flag, status bit 27. Writing a 1 to status bit 27 clears that flag.
- R5: The receive queue holds 4 words. Words pushed by `eng_rx_push` are returned by reads of address 3 in push order. After four pushes, status bit 24 (receive full) is set and bit 25 is clear.
- R6: Writing a 1 to status bit 29 empties the transmit queue, and writing a 1 to status bit 28 empties the receive queue.
- R7: When the block is idle, a control write (address 1) with bit 31 set produces a one-cycle `eng_start` pulse, sets busy (status bit 31), and drives `eng_words` with control bits 15:0. This field holds the word count minus one.
- R8: Busy stays set until `eng_word_done` has pulsed (count field + 1) times. On the last pulse, busy clears, ready (status bit 30) sets, and control bit 31 reads back 0.
- R9: `irq` equals ready AND (control bit 27 OR control bit 26), the transmit and receive completion enables. It stays high until a 1 is written to status bit 30.
- R10: `tx_req` is high when the free transmit entries reach the level set by control bit 16. `rx_req` is high when the stored receive words reach the level set by control bit 18. For both bits, code 0 means 1 word and code 1 means 4 words.
- R11: A control write while busy has no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Bus access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while the access is presented |
| eng_start | output | 1 | One-cycle block start strobe |
| eng_words | output | 16 | Block length minus one |
| eng_word_done | input | 1 | One word of the block has been shifted |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head transmit word |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_space | output | 1 | Receive queue not full |
| tx_req | output | 1 | Transmit level request |
| rx_req | output | 1 | Receive level request |
| irq | output | 1 | Block completion interrupt |

## Verification
The bench uses the default values: a queue depth of 4 and a 16-bit block count. With a depth of 4, a handful of bus writes or engine pushes reaches both full flags, the overflow and underflow paths, and the four-word request level. A block length of three words is enough to show that busy outlasts all but the final word-done pulse. A one-word block shows that ready without an enable leaves `irq` low.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
   typedef enum logic [1:0] {
      A_STATUS = 2'd0,
      A_CTRL   = 2'd1,
      A_TXD    = 2'd2,
      A_RXD    = 2'd3
   } reg_addr_e;

   // status word bit positions
   localparam int ST_BUSY   = 31;
   localparam int ST_READY  = 30;
   localparam int ST_TXFLSH = 29;
   localparam int ST_RXFLSH = 28;
   localparam int ST_RXUNF  = 27;
   localparam int ST_TXOVF  = 26;
   localparam int ST_RXEMP  = 25;
   localparam int ST_RXFUL  = 24;
   localparam int ST_TXEMP  = 23;
   localparam int ST_TXFUL  = 22;

   // control word bit positions
   localparam int CT_GO     = 31;
   localparam int CT_IETX   = 27;
   localparam int CT_IERX   = 26;
   localparam int CT_RXLVL  = 18;
   localparam int CT_TXLVL  = 16;
endpackage

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end
endmodule

// File: rtl/spi_buf_seq.sv
module spi_buf_seq #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             word_done,
   input  logic [CNT_W-1:0] blk_last,
   output logic             busy,
   output logic             start_pulse,
   output logic             finish
);
   logic [CNT_W-1:0] done_cnt;

   assign finish = busy && word_done && (done_cnt == blk_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         start_pulse <= 1'b0;
         done_cnt    <= '0;
      end else begin
         start_pulse <= 1'b0;
         if (go && !busy) begin
            busy        <= 1'b1;
            start_pulse <= 1'b1;
            done_cnt    <= '0;
         end else if (finish) begin
            busy <= 1'b0;
         end else if (busy && word_done) begin
            done_cnt <= done_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
   import spi_buf_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int CNT_W      = 16,
   localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_en,
   input  logic        reg_we,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        eng_start,
   output logic [15:0] eng_words,
   input  logic        eng_word_done,
   input  logic        eng_tx_pop,
   output logic [31:0] eng_tx_data,
   output logic        eng_tx_avail,
   input  logic        eng_rx_push,
   input  logic [31:0] eng_rx_data,
   output logic        eng_rx_space,
   output logic        tx_req,
   output logic        rx_req,
   output logic        irq
);
   generate
      if (FIFO_DEPTH < 4) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 4 for the four-word level");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
   endgenerate

   logic wr_stat, wr_ctrl, wr_tx, rd_rx, ctrl_load, go;
   logic busy_w, finish_w;
   logic ready_q, tx_ovf_q, rx_unf_q;
   logic en_q, ie_tx_q, ie_rx_q, tx_lvl_q, rx_lvl_q;
   logic [CNT_W-1:0] blk_q;
   logic [CW-1:0] tx_cnt, rx_cnt, tx_free, tx_need, rx_need;
   logic tx_full_w, tx_empty_w, rx_full_w, rx_empty_w;
   logic [31:0] rx_head, stat_rd, ctrl_rd;

   assign wr_stat   = reg_en && reg_we && (reg_addr == A_STATUS);
   assign wr_ctrl   = reg_en && reg_we && (reg_addr == A_CTRL);
   assign wr_tx     = reg_en && reg_we && (reg_addr == A_TXD);
   assign rd_rx     = reg_en && !reg_we && (reg_addr == A_RXD);
   assign ctrl_load = wr_ctrl && !busy_w;
   assign go        = ctrl_load && reg_wdata[CT_GO];

   spi_buf_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .flush(wr_stat && reg_wdata[ST_TXFLSH]),
      .push(wr_tx), .din(reg_wdata),
      .pop(eng_tx_pop), .dout(eng_tx_data),
      .count(tx_cnt), .full(tx_full_w), .empty(tx_empty_w)
   );

   spi_buf_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .flush(wr_stat && reg_wdata[ST_RXFLSH]),
      .push(eng_rx_push), .din(eng_rx_data),
      .pop(rd_rx), .dout(rx_head),
      .count(rx_cnt), .full(rx_full_w), .empty(rx_empty_w)
   );

   spi_buf_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .go(go), .word_done(eng_word_done), .blk_last(blk_q),
      .busy(busy_w), .start_pulse(eng_start), .finish(finish_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         tx_ovf_q <= 1'b0;
         rx_unf_q <= 1'b0;
      end else begin
         if (finish_w)                              ready_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_READY])   ready_q <= 1'b0;
         if (wr_tx && tx_full_w)                    tx_ovf_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_TXOVF])   tx_ovf_q <= 1'b0;
         if (rd_rx && rx_empty_w)                   rx_unf_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_RXUNF])   rx_unf_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         ie_tx_q  <= 1'b0;
         ie_rx_q  <= 1'b0;
         tx_lvl_q <= 1'b0;
         rx_lvl_q <= 1'b0;
         blk_q    <= '0;
      end else if (ctrl_load) begin
         en_q     <= reg_wdata[CT_GO];
         ie_tx_q  <= reg_wdata[CT_IETX];
         ie_rx_q  <= reg_wdata[CT_IERX];
         tx_lvl_q <= reg_wdata[CT_TXLVL];
         rx_lvl_q <= reg_wdata[CT_RXLVL];
         blk_q    <= reg_wdata[CNT_W-1:0];
      end else if (finish_w) begin
         en_q <= 1'b0;
      end
   end

   always_comb begin
      stat_rd = '0;
      stat_rd[ST_BUSY]  = busy_w;
      stat_rd[ST_READY] = ready_q;
      stat_rd[ST_RXUNF] = rx_unf_q;
      stat_rd[ST_TXOVF] = tx_ovf_q;
      stat_rd[ST_RXEMP] = rx_empty_w;
      stat_rd[ST_RXFUL] = rx_full_w;
      stat_rd[ST_TXEMP] = tx_empty_w;
      stat_rd[ST_TXFUL] = tx_full_w;
      ctrl_rd = '0;
      ctrl_rd[CT_GO]    = en_q;
      ctrl_rd[CT_IETX]  = ie_tx_q;
      ctrl_rd[CT_IERX]  = ie_rx_q;
      ctrl_rd[CT_RXLVL] = rx_lvl_q;
      ctrl_rd[CT_TXLVL] = tx_lvl_q;
      ctrl_rd[CNT_W-1:0] = blk_q;
      case (reg_addr)
         A_STATUS: reg_rdata = stat_rd;
         A_CTRL:   reg_rdata = ctrl_rd;
         A_RXD:    reg_rdata = rx_empty_w ? 32'd0 : rx_head;
         default:  reg_rdata = 32'd0;
      endcase
   end

   assign tx_free      = CW'(FIFO_DEPTH) - tx_cnt;
   assign tx_need      = tx_lvl_q ? CW'(4) : CW'(1);
   assign rx_need      = rx_lvl_q ? CW'(4) : CW'(1);
   assign tx_req       = (tx_free >= tx_need);
   assign rx_req       = (rx_cnt >= rx_need);
   assign eng_tx_avail = !tx_empty_w;
   assign eng_rx_space = !rx_full_w;
   assign eng_words    = 16'(blk_q);
   assign irq          = ready_q && (ie_tx_q || ie_rx_q);
endmodule

// File: rtl/spi_buf_chk.sv
module spi_buf_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        ready,
   input logic        irq,
   input logic        start,
   input logic        tx_full,
   input logic        tx_empty,
   input logic        tx_ovf,
   input logic        reg_en,
   input logic        reg_we,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata
);
   logic ovf_clr;
   assign ovf_clr = reg_en && reg_we && (reg_addr == 2'd0) && reg_wdata[26];

   // R7
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> busy);
   // R7
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
   // R8
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ready);
   // R9
   irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ready);
   // R2
   tx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));
   // R3
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !ovf_clr) |=> tx_ovf);
endmodule

bind spi_buf_ctrl spi_buf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_w), .ready(ready_q), .irq(irq),
   .start(eng_start), .tx_full(tx_full_w), .tx_empty(tx_empty_w),
   .tx_ovf(tx_ovf_q), .reg_en(reg_en), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/spi_buf_ctrl_bench.sv
module spi_buf_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_en = 0, reg_we = 0;
   logic [1:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic eng_start, eng_word_done = 0, eng_tx_pop = 0, eng_tx_avail;
   logic [15:0] eng_words;
   logic [31:0] eng_tx_data, eng_rx_data = 0;
   logic eng_rx_push = 0, eng_rx_space, tx_req, rx_req, irq;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_buf_ctrl u_spi_buf_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_start(eng_start), .eng_words(eng_words),
      .eng_word_done(eng_word_done), .eng_tx_pop(eng_tx_pop),
      .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_rx_space(eng_rx_space), .tx_req(tx_req), .rx_req(rx_req), .irq(irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 0; reg_we = 0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_en = 1; reg_we = 0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_en = 0;
   endtask

   task automatic rx_push(logic [31:0] d);
      @(negedge clk);
      eng_rx_push = 1; eng_rx_data = d;
      @(negedge clk);
      eng_rx_push = 0;
   endtask

   task automatic tx_pop(string tag, logic [31:0] exp);
      @(negedge clk);
      check(tag, eng_tx_data, exp);
      eng_tx_pop = 1;
      @(negedge clk);
      eng_tx_pop = 0;
   endtask

   task automatic word_done();
      @(negedge clk);
      eng_word_done = 1;
      @(negedge clk);
      eng_word_done = 0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_read(2'd0, d);
      check("R1 status", d, 32'h0280_0000);
      check("R1 irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_tx();
      logic [31:0] d;
      bus_write(2'd1, 32'h0001_0000);
      check("R10 tx_req lvl4 empty", {31'd0, tx_req}, 32'd1);
      bus_write(2'd2, 32'hA000_0000);
      check("R10 tx_req lvl4 one used", {31'd0, tx_req}, 32'd0);
      for (int i = 1; i < 4; i++) bus_write(2'd2, 32'hA000_0000 + i);
      bus_read(2'd0, d);
      check("R2 full status", d, 32'h0240_0000);
      bus_write(2'd2, 32'hDEAD_BEEF);
      bus_read(2'd0, d);
      check("R3 overflow set", d, 32'h0640_0000);
      for (int i = 0; i < 4; i++) tx_pop("R2 tx order", 32'hA000_0000 + i);
      bus_read(2'd0, d);
      check("R3 overflow sticky", d, 32'h0680_0000);
      bus_write(2'd0, 32'h0400_0000);
      bus_read(2'd0, d);
      check("R3 overflow cleared", d, 32'h0280_0000);
   endtask

   task automatic t_rx();
      logic [31:0] d;
      bus_write(2'd1, 32'h0004_0000);
      for (int i = 0; i < 3; i++) rx_push(32'hB000_0000 + i);
      check("R10 rx_req three words", {31'd0, rx_req}, 32'd0);
      rx_push(32'hB000_0003);
      check("R10 rx_req four words", {31'd0, rx_req}, 32'd1);
      bus_read(2'd0, d);
      check("R5 full status", d, 32'h0180_0000);
      for (int i = 0; i < 4; i++) begin
         bus_read(2'd3, d);
         check("R5 rx order", d, 32'hB000_0000 + i);
      end
      bus_read(2'd3, d);
      check("R4 empty read value", d, 32'd0);
      bus_read(2'd0, d);
      check("R4 underflow set", d, 32'h0A80_0000);
      bus_write(2'd0, 32'h0800_0000);
      bus_read(2'd0, d);
      check("R4 underflow cleared", d, 32'h0280_0000);
   endtask

   task automatic t_flush();
      logic [31:0] d;
      bus_write(2'd2, 32'h1111_1111);
      bus_write(2'd2, 32'h2222_2222);
      rx_push(32'h3333_3333);
      rx_push(32'h4444_4444);
      bus_read(2'd0, d);
      check("R6 before flush", d, 32'h0000_0000);
      bus_write(2'd0, 32'h3000_0000);
      bus_read(2'd0, d);
      check("R6 after flush", d, 32'h0280_0000);
      check("R6 tx avail", {31'd0, eng_tx_avail}, 32'd0);
   endtask

   task automatic t_block();
      logic [31:0] d;
      bus_write(2'd1, 32'h8C00_0002);
      check("R7 start pulse", {31'd0, eng_start}, 32'd1);
      check("R7 words", {16'd0, eng_words}, 32'd2);
      @(negedge clk);
      check("R7 start one cycle", {31'd0, eng_start}, 32'd0);
      bus_read(2'd0, d);
      check("R7 busy", d, 32'h8280_0000);
      bus_write(2'd1, 32'h0000_0005);
      bus_read(2'd1, d);
      check("R11 ctrl unchanged", d, 32'h8C00_0002);
      word_done();
      word_done();
      bus_read(2'd0, d);
      check("R8 still busy", d, 32'h8280_0000);
      word_done();
      bus_read(2'd0, d);
      check("R8 done status", d, 32'h4280_0000);
      bus_read(2'd1, d);
      check("R8 enable cleared", d, 32'h0C00_0002);
      repeat (3) @(negedge clk);
      check("R9 irq held", {31'd0, irq}, 32'd1);
      bus_write(2'd0, 32'h4000_0000);
      check("R9 irq cleared", {31'd0, irq}, 32'd0);
      bus_read(2'd0, d);
      check("R9 ready cleared", d, 32'h0280_0000);
   endtask

   task automatic t_irq_gate();
      logic [31:0] d;
      bus_write(2'd1, 32'h8000_0000);
      word_done();
      bus_read(2'd0, d);
      check("R8 one word block", d, 32'h4280_0000);
      check("R9 irq gated off", {31'd0, irq}, 32'd0);
      bus_write(2'd0, 32'h4000_0000);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_tx();
      t_rx();
      t_flush();
      t_block();
      t_irq_gate();
      summary();
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule